// File: doc/BRIEF.md
# Dual-Target Interrupt Router

This block collects level interrupt status from a set of functional modules and steers each one to one of two consumers: an embedded microcontroller or an external host that watches a single interrupt pin. A direction mask decides the target of each source. The mask sits on a register bus that both processors share, so either side can re-steer any source at run time.

Sources steered to the same target are OR-combined into one interrupt for that target. The microcontroller line is combinational. The external pin is registered. Each processor can also read a per-target index view, which shows which of its own sources are pending at that moment. The views are derived live from the source lines and hold no state, so writing to them does nothing. A source can only be cleared in the module that raised it.

Top module: `irq_router`

## Requirements
- R1: After reset the direction mask is all zero, so every source goes to the internal target. `irq_ext` and `bus_rdata` are 0.
- R2: A write to address 0 loads the direction mask from `bus_wdata`. A read of address 0 returns the mask. Mask bit i = 1 steers source i to the external target, and 0 steers it to the internal target.
- R3: `irq_int` is high in the same cycle as any source whose mask bit is 0, and low when no such source is pending.
- R4: `irq_ext` is the registered OR of the sources whose mask bit is 1. It rises one clock after such a source rises, and falls one clock after the last such source clears.
- R5: A read of address 1 returns the internal index: source status AND NOT mask, bit i for source i.
- R6: A read of address 2 returns the external index: source status AND mask, bit i for source i.
- R7: Writes to address 1, 2 or 3 have no effect. The mask read back afterwards is unchanged, and the index views still follow the sources.
- R8: `bus_rdata` is valid one clock after the cycle where `bus_rd` is high. It holds its value until the next read. A read of address 3 returns 0.
- R9: A source stays visible in its index view and keeps its target interrupt asserted until it clears at its origin. After that, the next read shows the bit as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_pend | input | NSRC | Level status from the source modules |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Read data, one cycle after the read strobe |
| irq_int | output | 1 | Merged interrupt to the microcontroller |
| irq_ext | output | 1 | Registered merged interrupt pin to the external host |

## Verification
The assertions assume that `bus_rd` and `bus_wr` are never high in the same cycle. They also assume `src_pend` changes only between clock edges and stays steady across each edge. The stimulus meets both conditions. Every bus access is a single-strobe cycle, and every input is driven a short delay after the rising edge. The sticky source bits in the bench change only through their own set and clear calls. The mask is therefore the only state that moves a source between targets.

// File: rtl/irq_router.sv
module irq_router #(
  parameter int NSRC = 16,
  parameter int AW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_pend,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [AW-1:0]   bus_addr,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  output logic            irq_int,
  output logic            irq_ext
);
  localparam logic [AW-1:0] A_DIR  = AW'(0);
  localparam logic [AW-1:0] A_IIDX = AW'(1);
  localparam logic [AW-1:0] A_EIDX = AW'(2);

  logic [NSRC-1:0] dir_q;
  logic [NSRC-1:0] int_view;
  logic [NSRC-1:0] ext_view;
  logic [NSRC-1:0] rd_mux;

  assign int_view = src_pend & ~dir_q;
  assign ext_view = src_pend & dir_q;
  assign irq_int  = |int_view;

  always_comb begin
    case (bus_addr)
      A_DIR:   rd_mux = dir_q;
      A_IIDX:  rd_mux = int_view;
      A_EIDX:  rd_mux = ext_view;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_q     <= '0;
      irq_ext   <= 1'b0;
      bus_rdata <= '0;
    end else begin
      if (bus_wr && bus_addr == A_DIR) dir_q <= bus_wdata;
      irq_ext <= |ext_view;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr == A_DIR |=> dir_q == $past(bus_wdata));
  a_r7_view_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && bus_addr != A_DIR |=> $stable(dir_q));
  a_r3_int_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pend & ~dir_q) == '0 |-> !irq_int);
  a_r4_ext_registered: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_ext == $past(|(src_pend & dir_q)));
  a_r5_views_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (int_view & ext_view) == '0 && (int_view | ext_view) == src_pend);
  a_r8_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  a_r8_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && bus_addr == AW'(3) |=> bus_rdata == '0);
endmodule

// File: tb/tb_irq_router.sv
module tb_irq_router;
  localparam int NSRC = 16;
  localparam int AW   = 2;
  localparam int TCLK = 10;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src_pend = '0;
  logic            bus_wr = 1'b0;
  logic            bus_rd = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            irq_int;
  logic            irq_ext;

  int checks = 0;
  int errors = 0;
  logic [NSRC-1:0] dir_m = '0;
  logic [NSRC-1:0] exp_q[$];
  string           tag_q[$];
  logic            due = 1'b0;
  logic [NSRC-1:0] last_rd = '0;

  always #(TCLK/2) clk = ~clk;

  irq_router #(.NSRC(NSRC), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n), .src_pend(src_pend),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_int(irq_int), .irq_ext(irq_ext));

  task automatic check(input string tag, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data one cycle after each read strobe
  always @(negedge clk) begin
    if (due) begin
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8 actual unexpected-read expected none");
      end else begin
        last_rd = exp_q.pop_front();
        check(tag_q.pop_front(), bus_rdata, last_rd);
      end
    end
    due <= bus_rd;
  end

  task automatic wr_reg(input logic [AW-1:0] a, input logic [NSRC-1:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (a == 0) dir_m = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [AW-1:0] a, input string tag);
    logic [NSRC-1:0] e;
    @(posedge clk); #1;
    bus_rd = 1'b1; bus_addr = a;
    case (a)
      0: e = dir_m;
      1: e = src_pend & ~dir_m;
      2: e = src_pend & dir_m;
      default: e = '0;
    endcase
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic set_src(input logic [NSRC-1:0] v);
    @(posedge clk); #1;
    src_pend = src_pend | v;
  endtask

  task automatic clr_src(input logic [NSRC-1:0] v);
    @(posedge clk); #1;
    src_pend = src_pend & ~v;
  endtask

  task automatic drain;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_irqs(input string tag);
    @(negedge clk);
    check({tag, " irq_int"}, NSRC'(irq_int), NSRC'(|(src_pend & ~dir_m)));
    check({tag, " irq_ext"}, NSRC'(irq_ext), NSRC'(|(src_pend & dir_m)));
  endtask

  initial begin
    #(TCLK * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 irq_ext reset", NSRC'(irq_ext), '0);
    check("R1 rdata reset", bus_rdata, '0);
    @(posedge clk); #1 rst_n = 1'b1;
    rd_reg(0, "R1 dir reset");
    drain();

    // R3: internal merge, combinational
    set_src(16'h0004);
    @(negedge clk);
    check("R3 int same cycle", NSRC'(irq_int), 1);
    check("R3 ext stays low", NSRC'(irq_ext), 0);
    rd_reg(1, "R5 int view");
    rd_reg(2, "R6 ext view empty");

    // R2: steer some sources external
    wr_reg(0, 16'hA00C);
    rd_reg(0, "R2 dir readback");
    drain();
    check_irqs("R2 after steer");

    // R4: rise latency of the pin
    clr_src(16'hFFFF);
    drain();
    set_src(16'h2000);
    @(negedge clk);
    check("R4 ext before edge", NSRC'(irq_ext), 0);
    @(negedge clk);
    check("R4 ext after edge", NSRC'(irq_ext), 1);
    set_src(16'h8000);
    rd_reg(2, "R6 ext view two");
    rd_reg(1, "R5 int view none");
    // R4/R9: fall only after the last external source clears
    clr_src(16'h2000);
    @(negedge clk);
    @(negedge clk);
    check("R9 ext held by other", NSRC'(irq_ext), 1);
    clr_src(16'h8000);
    @(negedge clk);
    check("R4 ext before fall edge", NSRC'(irq_ext), 1);
    @(negedge clk);
    check("R4 ext fall", NSRC'(irq_ext), 0);
    rd_reg(2, "R9 view cleared");

    // R7: writes to views and unused address ignored
    set_src(16'h0301);
    wr_reg(1, 16'hFFFF);
    wr_reg(2, 16'h0000);
    wr_reg(3, 16'h1234);
    rd_reg(0, "R7 dir unchanged");
    rd_reg(1, "R7 int view live");
    rd_reg(2, "R7 ext view live");
    drain();
    check_irqs("R7 irqs");

    // R8: unused address and hold
    rd_reg(3, "R8 addr3 zero");
    rd_reg(1, "R8 last read");
    drain();
    repeat (4) @(negedge clk);
    check("R8 rdata hold", bus_rdata, last_rd);

    // R9: clearing at origin removes internal interrupt
    clr_src(16'h0301);
    @(negedge clk);
    check("R9 int cleared", NSRC'(irq_int), 0);
    rd_reg(1, "R9 int view cleared");

    // several patterns with full re-steer
    for (int k = 0; k < 6; k++) begin
      logic [NSRC-1:0] d;
      logic [NSRC-1:0] s;
      d = NSRC'(16'h1357 * (k + 3)) ^ NSRC'(k << 4);
      s = NSRC'(16'h2F1B * (k + 1)) ^ NSRC'(k);
      wr_reg(0, d);
      clr_src(16'hFFFF);
      set_src(s);
      rd_reg(1, "R5 pattern int");
      rd_reg(2, "R6 pattern ext");
      rd_reg(0, "R2 pattern dir");
      drain();
      check_irqs("R3 R4 pattern");
    end

    drain();
    check("R8 queue empty", NSRC'(exp_q.size()), '0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule